// File: doc/BRIEF.md
# Byte-Lane String Access Unit

This unit reads or writes one byte of a character string held in a memory of 16-bit words. The caller supplies the word address where the string starts and the position of the byte within it. Two bytes share each word: the byte at an even position sits in the upper half and the byte at the odd position that follows it sits in the lower half. The unit turns the byte position into a word address and a half select. It then runs a short transaction on a synchronous single-port memory.

A read fetches the word and returns the chosen byte in the low bits of a zero-filled result. A write reads the word, clears the chosen half, inserts the new byte there and writes the word back. The other half of the word keeps its value. The caller raises `start_i` for one cycle while the unit is idle, and waits for the one-cycle `done_o` pulse.

Top module: `byte_str_unit`

## Requirements
- R1: While `rst_ni` is low, `done_o`, `mem_we_o` and `busy_o` are 0 and `rdata_o` is 0.
- R2: The word accessed is `base_i + (idx_i >> 1)`, taken modulo 2^ADDR_W. It is presented on `mem_addr_o` from the cycle after `start_i` is accepted until the operation ends.
- R3: `idx_i[0] = 0` selects bits [15:8] of the word. `idx_i[0] = 1` selects bits [7:0].
- R4: When a read finishes, `rdata_o[7:0]` holds the selected byte and `rdata_o[15:8]` is 0.
- R5: A write stores `wbyte_i` into the selected half and leaves the other half of that word, and every other word, unchanged.
- R6: A read asserts `done_o` for exactly one cycle, two clock edges after the edge that accepts `start_i`. `mem_we_o` stays low during a read.
- R7: A write has one read cycle and then exactly one cycle with `mem_we_o` high, at the same address. `done_o` pulses once, three edges after acceptance.
- R8: `start_i` is ignored while `busy_o` is high. The running operation keeps its address, data and timing, and no second operation follows.
- R9: `rdata_o` changes only when a read finishes. A write leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an operation (sampled when idle) |
| wr_i | input | 1 | 1 = write, 0 = read |
| base_i | input | ADDR_W | Word address of the string start |
| idx_i | input | IDX_W | Byte position within the string |
| wbyte_i | input | BYTE_W | Byte to store on a write |
| rdata_o | output | 2*BYTE_W | Zero-extended byte from the last read |
| done_o | output | 1 | One-cycle completion pulse |
| busy_o | output | 1 | Operation in progress |
| mem_addr_o | output | ADDR_W | Memory word address |
| mem_rdata_i | input | 2*BYTE_W | Memory read data, one cycle after the address |
| mem_wdata_o | output | 2*BYTE_W | Memory write data |
| mem_we_o | output | 1 | Memory write enable |

## Verification
The bench keeps a byte-level shadow of the whole memory and compares every word after each operation. A merge that used the wrong mask or the wrong half would show up there as a corrupted neighbour byte. Reads at both even and odd positions catch a missing rotation or a swapped lane, because the byte would come back in the upper half or the wrong byte would be returned. One write uses a base near the top of the address space, so a carry that was dropped or mis-sized would land on the wrong word. A start pulse issued during a write checks that a design which re-accepted it would change the address or add an extra done pulse.

// File: rtl/byte_str_pkg.sv
package byte_str_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_CAP  = 2'd2,
    ST_WR   = 2'd3
  } bsu_state_e;
endpackage

// File: rtl/bsu_addr_gen.sv
module bsu_addr_gen #(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 16
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic [ADDR_W-1:0] word_addr_o,
  output logic              hi_lane_o
);
  localparam int HALF_W = IDX_W - 1;

  logic [ADDR_W-1:0] offset;

  generate
    if (HALF_W >= ADDR_W) begin : g_trunc
      assign offset = idx_i[ADDR_W:1];
    end else begin : g_ext
      assign offset = {{(ADDR_W-HALF_W){1'b0}}, idx_i[IDX_W-1:1]};
    end
  endgenerate

  assign word_addr_o = base_i + offset;
  // even position lives in upper half
  assign hi_lane_o   = ~idx_i[0];
endmodule

// File: rtl/bsu_lane_unit.sv
module bsu_lane_unit #(
  parameter int BYTE_W = 8
) (
  input  logic                hi_i,
  input  logic [2*BYTE_W-1:0] word_i,
  input  logic [BYTE_W-1:0]   byte_i,
  output logic [2*BYTE_W-1:0] extract_o,
  output logic [2*BYTE_W-1:0] merge_o
);
  localparam int WORD_W = 2 * BYTE_W;

  logic [WORD_W-1:0] mask, masked, placed;

  always_comb begin
    mask   = hi_i ? {{BYTE_W{1'b1}}, {BYTE_W{1'b0}}} : {{BYTE_W{1'b0}}, {BYTE_W{1'b1}}};
    masked = word_i & mask;
    extract_o = hi_i ? {masked[BYTE_W-1:0], masked[WORD_W-1:BYTE_W]} : masked;
    placed = hi_i ? {byte_i, {BYTE_W{1'b0}}} : {{BYTE_W{1'b0}}, byte_i};
    merge_o = (word_i & ~mask) | placed;
  end
endmodule

// File: rtl/bsu_ctrl.sv
module bsu_ctrl
  import byte_str_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic                wr_i,
  input  logic [ADDR_W-1:0]   word_addr_i,
  input  logic                hi_i,
  input  logic [BYTE_W-1:0]   wbyte_i,
  input  logic [2*BYTE_W-1:0] extract_i,
  input  logic [2*BYTE_W-1:0] merge_i,
  output logic                hi_q_o,
  output logic [BYTE_W-1:0]   byte_q_o,
  output logic [ADDR_W-1:0]   mem_addr_o,
  output logic [2*BYTE_W-1:0] mem_wdata_o,
  output logic                mem_we_o,
  output logic [2*BYTE_W-1:0] rdata_o,
  output logic                done_o,
  output logic                busy_o
);
  localparam int WORD_W = 2 * BYTE_W;

  bsu_state_e        state_q;
  logic              wr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [WORD_W-1:0] wdata_q, rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      wr_q     <= 1'b0;
      hi_q_o   <= 1'b0;
      byte_q_o <= '0;
      addr_q   <= '0;
      wdata_q  <= '0;
      rdata_q  <= '0;
      done_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          addr_q   <= word_addr_i;
          hi_q_o   <= hi_i;
          wr_q     <= wr_i;
          byte_q_o <= wbyte_i;
          state_q  <= ST_RD;
        end
        ST_RD: state_q <= ST_CAP;
        ST_CAP: begin
          if (wr_q) begin
            wdata_q <= merge_i;
            state_q <= ST_WR;
          end else begin
            rdata_q <= extract_i;
            done_o  <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        ST_WR: begin
          done_o  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = wdata_q;
  assign mem_we_o    = (state_q == ST_WR);
  assign rdata_o     = rdata_q;
  assign busy_o      = (state_q != ST_IDLE);

  p_done_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_read_no_we_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !wr_q) |-> !mem_we_o);
  p_we_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> !mem_we_o);
  p_we_addr_stable_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> $stable(mem_addr_o));
  p_busy_addr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> $stable(mem_addr_o));
  p_rdata_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && wr_q) |=> $stable(rdata_o));
endmodule

// File: rtl/byte_str_unit.sv
module byte_str_unit #(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 16,
  parameter int BYTE_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic                wr_i,
  input  logic [ADDR_W-1:0]   base_i,
  input  logic [IDX_W-1:0]    idx_i,
  input  logic [BYTE_W-1:0]   wbyte_i,
  output logic [2*BYTE_W-1:0] rdata_o,
  output logic                done_o,
  output logic                busy_o,
  output logic [ADDR_W-1:0]   mem_addr_o,
  input  logic [2*BYTE_W-1:0] mem_rdata_i,
  output logic [2*BYTE_W-1:0] mem_wdata_o,
  output logic                mem_we_o
);
  localparam int WORD_W = 2 * BYTE_W;

  logic [ADDR_W-1:0] word_addr;
  logic              hi_lane, hi_q;
  logic [BYTE_W-1:0] byte_q;
  logic [WORD_W-1:0] extract, merge;

  bsu_addr_gen #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_addr (
    .base_i      (base_i),
    .idx_i       (idx_i),
    .word_addr_o (word_addr),
    .hi_lane_o   (hi_lane)
  );

  bsu_lane_unit #(.BYTE_W(BYTE_W)) u_lane (
    .hi_i      (hi_q),
    .word_i    (mem_rdata_i),
    .byte_i    (byte_q),
    .extract_o (extract),
    .merge_o   (merge)
  );

  bsu_ctrl #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .wr_i        (wr_i),
    .word_addr_i (word_addr),
    .hi_i        (hi_lane),
    .wbyte_i     (wbyte_i),
    .extract_i   (extract),
    .merge_i     (merge),
    .hi_q_o      (hi_q),
    .byte_q_o    (byte_q),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_we_o    (mem_we_o),
    .rdata_o     (rdata_o),
    .done_o      (done_o),
    .busy_o      (busy_o)
  );

  p_merge_keeps_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (hi_q ? (mem_wdata_o[BYTE_W-1:0] == $past(mem_rdata_i[BYTE_W-1:0]))
                       : (mem_wdata_o[WORD_W-1:BYTE_W] == $past(mem_rdata_i[WORD_W-1:BYTE_W]))));
  p_rdata_upper_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[WORD_W-1:BYTE_W] == '0);
endmodule

// File: tb/byte_str_unit_tb_top.sv
`timescale 1ns/1ps
module byte_str_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, wr = 1'b0;
  logic [15:0] base = '0, idx = '0;
  logic [7:0]  wbyte = '0;
  logic [15:0] rdata, mem_addr, mem_wdata, mem_rdata;
  logic        done, busy, mem_we;

  logic [15:0] mem [64];
  logic [7:0]  shadow [128];
  int checks = 0, fails = 0;
  logic [15:0] last_rd = '0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  byte_str_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .wr_i(wr),
    .base_i(base), .idx_i(idx), .wbyte_i(wbyte),
    .rdata_o(rdata), .done_o(done), .busy_o(busy),
    .mem_addr_o(mem_addr), .mem_rdata_i(mem_rdata),
    .mem_wdata_o(mem_wdata), .mem_we_o(mem_we)
  );

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr[5:0]] <= mem_wdata;
    mem_rdata <= mem[mem_addr[5:0]];
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_mem(input string req);
    int bad = -1;
    for (int w = 0; w < 64; w++)
      if (bad < 0 && mem[w] !== {shadow[2*w], shadow[2*w+1]}) bad = w;
    if (bad < 0) chk(1, req, 0, 0);
    else chk(0, req, mem[bad], {shadow[2*bad], shadow[2*bad+1]});
  endtask

  task automatic run_op(input bit w, input logic [15:0] b, input logic [15:0] ix,
                        input logic [7:0] d, input bit poke);
    logic [15:0] wa;
    int abs_i, done_c, we_c, done_n;
    wa = b + (ix >> 1);
    abs_i = 2 * int'(wa[5:0]) + int'(ix[0]);
    @(negedge clk);
    start = 1; wr = w; base = b; idx = ix; wbyte = d;
    @(negedge clk);
    start = 0;
    if (poke) begin start = 1; wr = 1; base = b + 16'd5; idx = ix + 16'd3; wbyte = ~d; end
    chk(busy === 1'b1, "R8 busy after accept", busy, 1);
    chk(mem_addr === wa, "R2 word address", mem_addr, wa);
    done_c = 0; we_c = 0; done_n = 0;
    for (int c = 1; c <= 20 && done_c == 0; c++) begin
      @(negedge clk);
      if (c == 1) start = 0;
      if (mem_we) begin
        we_c++;
        chk(mem_addr === wa, "R7 write address", mem_addr, wa);
      end
      if (busy && !done) chk(mem_addr === wa, "R8 address held", mem_addr, wa);
      if (done) begin done_c = c; done_n++; end
    end
    if (w) begin
      chk(done_c == 3, "R7 write done latency", done_c, 3);
      chk(we_c == 1, "R7 single write strobe", we_c, 1);
      chk(rdata === last_rd, "R9 rdata held on write", rdata, last_rd);
      shadow[abs_i] = d;
    end else begin
      chk(done_c == 2, "R6 read done latency", done_c, 2);
      chk(we_c == 0, "R6 no write on read", we_c, 0);
      chk(rdata === {8'h00, shadow[abs_i]}, ix[0] ? "R3/R4 odd read" : "R3/R4 even read",
          rdata, {8'h00, shadow[abs_i]});
      last_rd = rdata;
    end
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      if (done || busy) done_n++;
    end
    chk(done_n == 1, "R8 single completion", done_n, 1);
    check_mem("R5 memory matches shadow");
  endtask

  initial begin
    for (int w = 0; w < 64; w++) begin
      mem[w] = 16'($urandom);
      shadow[2*w]   = mem[w][15:8];
      shadow[2*w+1] = mem[w][7:0];
    end
    repeat (3) @(negedge clk);
    chk(done === 1'b0, "R1 done in reset", done, 0);
    chk(mem_we === 1'b0, "R1 we in reset", mem_we, 0);
    chk(busy === 1'b0, "R1 busy in reset", busy, 0);
    chk(rdata === 16'h0, "R1 rdata in reset", rdata, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    // directed lane cases
    run_op(0, 16'd4, 16'd6, 8'h00, 0);
    run_op(0, 16'd4, 16'd7, 8'h00, 0);
    run_op(1, 16'd10, 16'd0, 8'hA5, 0);
    run_op(1, 16'd10, 16'd1, 8'h3C, 0);
    run_op(0, 16'd10, 16'd0, 8'h00, 0);
    run_op(0, 16'd10, 16'd1, 8'h00, 0);
    run_op(1, 16'd20, 16'd9, 8'hFF, 0);
    run_op(1, 16'd20, 16'd8, 8'h00, 0);
    // address wrap: 0xFFFF + 1 -> word 0
    run_op(1, 16'hFFFF, 16'd2, 8'h5E, 0);
    run_op(0, 16'hFFFF, 16'd3, 8'h00, 0);
    run_op(0, 16'hFFFF, 16'd2, 8'h00, 0);
    // start during busy
    run_op(1, 16'd2, 16'd5, 8'h77, 1);
    run_op(0, 16'd3, 16'd2, 8'h00, 1);
    for (int n = 0; n < 400; n++)
      run_op(1'($urandom), 16'($urandom_range(0, 31)), 16'($urandom_range(0, 63)),
             8'($urandom), (n % 17) == 0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule